// File: doc/BRIEF.md
# Level-Change Pulse Held to Reference Edge

This block watches one asynchronous data line and raises a flag every time that line changes level, in either direction. The flag stays high until the next rising edge of a separate, free-running reference clock, and drops at that edge. Everything runs in a fast system clock domain. Both the data line and the reference clock are first passed through two-stage synchronizers. Change detection compares each synchronized data sample with the sample taken one cycle earlier. A reference rising edge is found when the synchronized reference is 1 and the previous synchronized reference was 0.

The hold element is a two-state machine. ST_IDLE means the output is low and ST_HOLD means the output is high. The machine has three transitions. SET_ON_CHANGE goes from ST_IDLE to ST_HOLD on a detected change. CLEAR_ON_REF goes from ST_HOLD to ST_IDLE on a reference rising edge, but only when no change is detected in the same cycle. STAY keeps the current state in every other case. If a change and a reference rising edge are seen in the same system cycle, the machine ends in ST_HOLD. The change is therefore never lost, and the output waits for the following reference rising edge. The output comes straight from a register.

Top module: `toggle_hold_pulse`

## Requirements
- R1: While rst_n is low, pulse_out is 0.
- R2: A low-to-high change of data_in, held stable, drives pulse_out to 1 on the third rising edge of clk after the change and not before.
- R3: A high-to-low change of data_in also drives pulse_out to 1, with the same three-edge latency.
- R4: Once high, pulse_out stays high for any number of cycles in which no reference rising edge is seen.
- R5: A 0-to-1 change of ref_clk_in while pulse_out is high drives pulse_out to 0 on the third rising edge of clk after the change and not before.
- R6: A 1-to-0 change of ref_clk_in, and ref_clk_in resting high, have no effect on pulse_out.
- R7: When a data change and a reference rising edge reach the detectors in the same cycle, pulse_out stays 1 and is cleared only by the following reference rising edge.
- R8: Further data changes while pulse_out is high do not extend the pulse past the next reference rising edge.
- R9: When reset is released with data_in already high, no change is reported and pulse_out stays 0.
- R10: A reference rising edge while pulse_out is low leaves pulse_out at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| data_in | input | 1 | Asynchronous data line being watched |
| ref_clk_in | input | 1 | Asynchronous reference clock whose rising edge ends a pulse |
| pulse_out | output | 1 | Registered flag: high from a detected change until the next reference rising edge |

## Verification
The bench targets the case where a data change and a reference rising edge arrive together. A design in which clearing wins would drop that change, and the pulse would never appear. The bench checks the exact three-edge latency in both directions, so an extra or missing synchronizer stage shows up as an early or late output. It also releases reset with the data line already high: a delay register that does not track during reset would report a false change there. Finally, it covers reference falling edges, a reference held high, and repeated data changes during a pulse. These catch a design that clears on the wrong reference edge or on the reference level, and one that restarts the hold on every change.

// File: rtl/thp_pkg.sv
package thp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_t;

    localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/thp_sync.sv
module thp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Free-running chain: keeps tracking during reset so release is clean.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain_q[0] <= async_i;
        end else begin : g_multi
            always_ff @(posedge clk) chain_q <= {chain_q[LAST-1:0], async_i};
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/thp_edge.sv
module thp_edge #(
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic sig_i,
    output logic hit_o
);
    logic prev_q;

    // Delayed sample loads continuously, including during reset.
    always_ff @(posedge clk) prev_q <= sig_i;

    generate
        if (RISE_ONLY) begin : g_rise
            assign hit_o = sig_i & ~prev_q;
        end else begin : g_any
            assign hit_o = sig_i ^ prev_q;
        end
    endgenerate
endmodule

// File: rtl/thp_fsm.sv
module thp_fsm
    import thp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic change_i,
    input  logic ref_rise_i,
    output logic pulse_o
);
    hold_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (change_i) state_d = ST_HOLD;                     // SET_ON_CHANGE
            ST_HOLD: if (ref_rise_i && !change_i) state_d = ST_IDLE;      // CLEAR_ON_REF
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= (state_d == ST_HOLD);
    end

    AST_RESET_LOW:  assert property (@(posedge clk) !rst_n |=> !pulse_o);                                   // R1
    AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n) change_i |=> pulse_o);            // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (pulse_o && !ref_rise_i) |=> pulse_o); // R4
    AST_REF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (pulse_o && ref_rise_i && !change_i) |=> !pulse_o); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!pulse_o && !change_i) |=> !pulse_o); // R10
endmodule

// File: rtl/toggle_hold_pulse.sv
module toggle_hold_pulse
    import thp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    input  logic ref_clk_in,
    output logic pulse_out
);
    logic data_s, ref_s, change, ref_rise;

    thp_sync #(.STAGES(SYNC_STAGES)) u_sync_data (.clk(clk), .async_i(data_in),    .sync_o(data_s));
    thp_sync #(.STAGES(SYNC_STAGES)) u_sync_ref  (.clk(clk), .async_i(ref_clk_in), .sync_o(ref_s));

    thp_edge #(.RISE_ONLY(1'b0)) u_edge_data (.clk(clk), .sig_i(data_s), .hit_o(change));
    thp_edge #(.RISE_ONLY(1'b1)) u_edge_ref  (.clk(clk), .sig_i(ref_s),  .hit_o(ref_rise));

    thp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .change_i  (change),
        .ref_rise_i(ref_rise),
        .pulse_o   (pulse_out)
    );
endmodule

// File: tb/toggle_hold_pulse_tb.sv
module toggle_hold_pulse_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_in = 1'b0;
    logic ref_clk_in = 1'b0;
    logic pulse_out;
    int n_checks = 0;
    int n_fails = 0;

    always #2.5 clk = ~clk;

    toggle_hold_pulse u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .ref_clk_in(ref_clk_in), .pulse_out(pulse_out)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (pulse_out !== exp) begin
            n_fails++;
            $display("FAIL %s: pulse_out actual %b expected %b at %0t", req, pulse_out, exp, $time);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_r1_r9();
        rst_n = 1'b0; data_in = 1'b1; ref_clk_in = 1'b0;
        settle(6);
        check("R1", 1'b0);
        rst_n = 1'b1;
        settle(8);
        check("R9", 1'b0);
    endtask

    task automatic t_fall_r3_r4();
        data_in = 1'b0;
        settle(2);
        check("R3 early", 1'b0);
        settle(1);
        check("R3", 1'b1);
        settle(25);
        check("R4", 1'b1);
    endtask

    task automatic t_ref_clear_r5();
        ref_clk_in = 1'b1;
        settle(2);
        check("R5 early", 1'b1);
        settle(1);
        check("R5", 1'b0);
    endtask

    task automatic t_rise_r2_r6();
        data_in = 1'b1;
        settle(2);
        check("R2 early", 1'b0);
        settle(1);
        check("R2", 1'b1);
        ref_clk_in = 1'b0;
        settle(6);
        check("R6 falling", 1'b1);
    endtask

    task automatic t_idle_r10_r6();
        settle(10);
        check("R6 high level", 1'b0);
        ref_clk_in = 1'b0;
        settle(4);
        ref_clk_in = 1'b1;
        settle(6);
        check("R10", 1'b0);
        ref_clk_in = 1'b0;
        settle(4);
    endtask

    task automatic t_coincide_r7();
        data_in = ~data_in;
        ref_clk_in = 1'b1;
        settle(3);
        check("R7 set", 1'b1);
        settle(10);
        check("R7 hold", 1'b1);
        ref_clk_in = 1'b0;
        settle(4);
        check("R7 fall", 1'b1);
        ref_clk_in = 1'b1;
        settle(3);
        check("R7 clear", 1'b0);
        ref_clk_in = 1'b0;
        settle(4);
    endtask

    task automatic t_retrigger_r8();
        data_in = ~data_in;
        settle(4);
        check("R8 set", 1'b1);
        data_in = ~data_in;
        settle(4);
        check("R8 second", 1'b1);
        ref_clk_in = 1'b1;
        settle(3);
        check("R8 clear", 1'b0);
        settle(10);
        check("R8 stays low", 1'b0);
    endtask

    initial begin
        #1000000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_r1_r9();
        t_fall_r3_r4();
        t_ref_clear_r5();
        t_rise_r2_r6();
        t_ref_clear_r5();
        t_idle_r10_r6();
        t_coincide_r7();
        t_retrigger_r8();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule